// File: doc/BRIEF.md
# Region-Decoded Memory Access Router

This block sits between a processor's load/store unit and a set of small on-chip memories. Each request carries a 32-bit address, an access width (byte, halfword or word), a store flag, a sequential hint and an instruction-fetch flag. The top eight address bits select a region. Within a region, overlapping windows pick one of five byte-addressed banks: instruction scratchpad, data scratchpad, main RAM, shared work RAM and private work RAM. A sixth target is a plain 16-bit register port for the IO region. One registered response follows each accepted request. It holds the load data, a cycle cost taken from fixed per-region wait-state tables, and an error flag.

Loads that are not aligned are rotated as a processor expects. A fetch that finds no executable target returns a fixed undefined-instruction word. Data accesses that find no target read as zero and change nothing.

The request side is valid/ready. `req_ready` is high whenever the response register is empty, or is being emptied in the same cycle (`rsp_ready` high). A response stays valid and unchanged while `rsp_ready` is low, and no new request is taken during that time. The configuration pins are plain levels, sampled with each request.

Top module: `region_mem_router`

## Requirements
- R1: A request accepted on a clock edge (req_valid and req_ready both high) produces rsp_valid on the next cycle. While rsp_valid is high and rsp_ready is low, the response fields stay unchanged and req_ready is low.
- R2: Region r = addr[31:24]. For regions 0..7 the wait tables are: non-sequential 16-bit 6,6,17,6,6,7,7,6; non-sequential 32-bit 6,6,19,6,6,9,9,6; sequential 16-bit 1,1,1,1,1,2,2,1; sequential 32-bit 1,1,3,1,1,4,4,1. Size encoding is 0 byte, 1 halfword, 2 or 3 word. Word accesses use the 32-bit tables and the other sizes use the 16-bit tables. req_seq=1 selects the sequential table. rsp_cost is the wait value plus 2 for a load, or plus 1 for a store.
- R3: Regions 8 to 255 have zero wait states, so a load costs 2 and a store costs 1.
- R4: In region 2, a data access whose address with its low log2(DTCM_BYTES) bits cleared equals cfg_dtcm_base goes to the data scratchpad, at index addr mod DTCM_BYTES. Every other region-2 access goes to main RAM at index addr mod MAIN_BYTES. Instruction fetches always use main RAM.
- R5: Regions 0 and 1 map to the instruction scratchpad (index addr mod ITCM_BYTES) only when addr < 512 << cfg_itcm_vsize. An access outside that window sets rsp_err. A store there writes nothing, and a load there returns 0.
- R6: In region 3, private work RAM is used when addr >= 0x0380_0000 or cfg_shr_bytes = 0. Otherwise shared work RAM is used, at index addr AND (cfg_shr_bytes-1).
- R7: A word load returns the aligned word rotated right by addr[1:0]*8. A halfword load returns the aligned halfword, zero-extended, rotated right by addr[0]*8. A byte load returns the byte zero-extended. Store responses carry rdata 0.
- R8: IO (region 4) uses addr[23:0]. A store pulses io_we in its accept cycle with io_waddr = addr[23:0], io_wdata and io_wsize. A word load returns {io_rdata1, io_rdata0}, with io_raddr0 = {addr[23:2],2'b00} and io_raddr1 = {addr[23:2],2'b10}. A halfword load reads io_rdata0 at addr[23:0]. Both are then rotated as in R7. A byte load returns io_rdata0[7:0].
- R9: An instruction fetch (req_fetch=1, req_write=0) that hits no executable target returns 0xE710B710 with rsp_err=1 and cost 2. Executable targets are the in-window instruction scratchpad, main RAM and work RAM.
- R10: A data access to a region other than 0..4 sets rsp_err. A load there returns 0, and a store changes nothing and raises no io_we.
- R11: A fetch that hits a target uses the non-sequential table for its width even when req_seq=1, plus 2.
- R12: While rst_n is low and after its release, rsp_valid is 0 and req_ready is 1 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_seq | input | 1 | Sequential-access hint |
| req_fetch | input | 1 | Instruction fetch (loads only) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, low-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Load result |
| rsp_cost | output | 5 | Cycle cost of the access |
| rsp_err | output | 1 | No target or out of window |
| cfg_itcm_vsize | input | 5 | Instruction window size exponent |
| cfg_dtcm_base | input | 32 | Data scratchpad base address |
| cfg_shr_bytes | input | SHR_CW (9) | Shared work RAM size in bytes, 0 = none |
| io_raddr0 | output | 24 | IO read lane 0 address |
| io_raddr1 | output | 24 | IO read lane 1 address |
| io_rdata0 | input | 16 | IO read lane 0 data |
| io_rdata1 | input | 16 | IO read lane 1 data |
| io_we | output | 1 | IO store strobe |
| io_waddr | output | 24 | IO store address |
| io_wdata | output | 32 | IO store data |
| io_wsize | output | 2 | IO store size |

## Verification
The hardest cases to reach are the ones where windows overlap. These are a region-2 address that lands on the data scratchpad and an alias of the same address that does not, an instruction-window alias that lies just past the size limit, and a work-RAM address whose target changes with the shared size. The stimulus first writes distinct marker words through each candidate target. It then reads back through the aliases, and changes cfg_itcm_vsize and cfg_shr_bytes between reads, so that each routing choice shows up as a different data word at the response port.

// File: rtl/rmr_pkg.sv
package rmr_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ITCM,
    TGT_DTCM,
    TGT_MAIN,
    TGT_SHR,
    TGT_PRV,
    TGT_IO
  } tgt_e;

  localparam logic [31:0] UNDEF_OPCODE = 32'hE710B710;
  localparam logic [4:0]  LOAD_EXTRA   = 5'd2;
  localparam logic [4:0]  STORE_EXTRA  = 5'd1;

  // Wait states for one region, width class and sequentiality.
  function automatic logic [4:0] base_wait(input logic [7:0] region,
                                           input logic wide,
                                           input logic seq);
    logic [4:0] w;
    w = 5'd0;
    if (region < 8'd8) begin
      unique case ({wide, seq})
        2'b00: w = (region == 8'd2) ? 5'd17 :
                   (region == 8'd5 || region == 8'd6) ? 5'd7 : 5'd6;
        2'b10: w = (region == 8'd2) ? 5'd19 :
                   (region == 8'd5 || region == 8'd6) ? 5'd9 : 5'd6;
        2'b01: w = (region == 8'd5 || region == 8'd6) ? 5'd2 : 5'd1;
        2'b11: w = (region == 8'd2) ? 5'd3 :
                   (region == 8'd5 || region == 8'd6) ? 5'd4 : 5'd1;
        default: w = 5'd0;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/rmr_decode.sv
module rmr_decode
  import rmr_pkg::*;
#(
  parameter int          ITCM_BYTES = 256,
  parameter int          DTCM_BYTES = 256,
  parameter int          MAIN_BYTES = 1024,
  parameter int          PRV_BYTES  = 256,
  parameter logic [31:0] PRV_BASE   = 32'h0380_0000,
  parameter int          SHR_CW     = 9
) (
  input  logic [31:0]       addr,
  input  logic              fetch,
  input  logic [4:0]        cfg_itcm_vsize,
  input  logic [31:0]       cfg_dtcm_base,
  input  logic [SHR_CW-1:0] cfg_shr_bytes,
  output tgt_e              tgt,
  output logic [23:0]       idx
);
  localparam logic [31:0] ITCM_M = 32'(ITCM_BYTES - 1);
  localparam logic [31:0] DTCM_M = 32'(DTCM_BYTES - 1);
  localparam logic [31:0] MAIN_M = 32'(MAIN_BYTES - 1);
  localparam logic [31:0] PRV_M  = 32'(PRV_BYTES - 1);

  logic [7:0]  region;
  logic [63:0] itcm_limit;
  logic [31:0] shr_m;
  logic [31:0] sel;

  assign region     = addr[31:24];
  assign itcm_limit = 64'd512 << cfg_itcm_vsize;
  assign shr_m      = 32'(cfg_shr_bytes) - 32'd1;
  assign idx        = sel[23:0];

  always_comb begin
    tgt = TGT_NONE;
    sel = 32'd0;
    unique case (region)
      8'h00, 8'h01: begin
        if ({32'd0, addr} < itcm_limit) begin
          tgt = TGT_ITCM;
          sel = addr & ITCM_M;
        end
      end
      8'h02: begin
        if (!fetch && ((addr & ~DTCM_M) == cfg_dtcm_base)) begin
          tgt = TGT_DTCM;
          sel = addr & DTCM_M;
        end else begin
          tgt = TGT_MAIN;
          sel = addr & MAIN_M;
        end
      end
      8'h03: begin
        if (addr >= PRV_BASE || cfg_shr_bytes == '0) begin
          tgt = TGT_PRV;
          sel = addr & PRV_M;
        end else begin
          tgt = TGT_SHR;
          sel = addr & shr_m;
        end
      end
      8'h04: begin
        if (!fetch) begin
          tgt = TGT_IO;
          sel = addr & 32'h00FF_FFFF;
        end
      end
      default: begin
        tgt = TGT_NONE;
        sel = 32'd0;
      end
    endcase
  end
endmodule

// File: rtl/rmr_cost.sv
module rmr_cost
  import rmr_pkg::*;
(
  input  logic [7:0] region,
  input  logic       wide,
  input  logic       seq,
  input  logic       write,
  input  logic       fetch,
  input  logic       fetch_bad,
  output logic [4:0] cost
);
  logic       seq_eff;
  logic [4:0] w;

  // Fetches are always costed as non-sequential.
  assign seq_eff = seq & ~fetch;
  assign w       = base_wait(region, wide, seq_eff);

  always_comb begin
    if (fetch_bad)   cost = LOAD_EXTRA;
    else if (write)  cost = w + STORE_EXTRA;
    else             cost = w + LOAD_EXTRA;
  end
endmodule

// File: rtl/rmr_bank.sv
module rmr_bank #(
  parameter int BYTES = 256,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rword
);
  logic [7:0]    mem [BYTES];
  logic [AW-1:0] wbase;
  logic [AW-1:0] rbase;
  logic [3:0]    lanes;

  always_comb begin
    unique case (size)
      2'd0: begin wbase = idx;                   lanes = 4'b0001; end
      2'd1: begin wbase = {idx[AW-1:1], 1'b0};   lanes = 4'b0011; end
      default: begin wbase = {idx[AW-1:2], 2'b00}; lanes = 4'b1111; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < 4; k++) begin
        if (lanes[k]) mem[wbase + AW'(k)] <= wdata[8*k +: 8];
      end
    end
  end

  assign rbase = {idx[AW-1:2], 2'b00};

  for (genvar g = 0; g < 4; g++) begin : g_rd
    assign rword[8*g +: 8] = mem[rbase + AW'(g)];
  end
endmodule

// File: rtl/region_mem_router.sv
module region_mem_router
  import rmr_pkg::*;
#(
  parameter int          ITCM_BYTES = 256,
  parameter int          DTCM_BYTES = 256,
  parameter int          MAIN_BYTES = 1024,
  parameter int          SHR_BYTES  = 256,
  parameter int          PRV_BYTES  = 256,
  parameter logic [31:0] PRV_BASE   = 32'h0380_0000,
  parameter int          SHR_CW     = $clog2(SHR_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_seq,
  input  logic              req_fetch,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [4:0]        rsp_cost,
  output logic              rsp_err,
  input  logic [4:0]        cfg_itcm_vsize,
  input  logic [31:0]       cfg_dtcm_base,
  input  logic [SHR_CW-1:0] cfg_shr_bytes,
  output logic [23:0]       io_raddr0,
  output logic [23:0]       io_raddr1,
  input  logic [15:0]       io_rdata0,
  input  logic [15:0]       io_rdata1,
  output logic              io_we,
  output logic [23:0]       io_waddr,
  output logic [31:0]       io_wdata,
  output logic [1:0]        io_wsize
);
  localparam int IT_AW = $clog2(ITCM_BYTES);
  localparam int DT_AW = $clog2(DTCM_BYTES);
  localparam int MN_AW = $clog2(MAIN_BYTES);
  localparam int SH_AW = $clog2(SHR_BYTES);
  localparam int PV_AW = $clog2(PRV_BYTES);

  tgt_e        tgt;
  logic [23:0] idx;
  logic        accept, fetch_eff, fetch_bad, wide, miss;
  logic [4:0]  cost;
  logic [31:0] w_itcm, w_dtcm, w_main, w_shr, w_prv;
  logic [31:0] bank_word, raw, rot, rdata_n;
  logic [4:0]  sh;

  assign accept    = req_valid & req_ready;
  assign req_ready = ~rsp_valid | rsp_ready;
  assign fetch_eff = req_fetch & ~req_write;
  assign wide      = req_size[1];
  assign miss      = (tgt == TGT_NONE);
  assign fetch_bad = fetch_eff & miss;

  rmr_decode #(
    .ITCM_BYTES(ITCM_BYTES), .DTCM_BYTES(DTCM_BYTES), .MAIN_BYTES(MAIN_BYTES),
    .PRV_BYTES(PRV_BYTES), .PRV_BASE(PRV_BASE), .SHR_CW(SHR_CW)
  ) u_dec (
    .addr(req_addr), .fetch(fetch_eff), .cfg_itcm_vsize(cfg_itcm_vsize),
    .cfg_dtcm_base(cfg_dtcm_base), .cfg_shr_bytes(cfg_shr_bytes),
    .tgt(tgt), .idx(idx)
  );

  rmr_cost u_cost (
    .region(req_addr[31:24]), .wide(wide), .seq(req_seq), .write(req_write),
    .fetch(fetch_eff), .fetch_bad(fetch_bad), .cost(cost)
  );

  rmr_bank #(.BYTES(ITCM_BYTES)) u_itcm (
    .clk(clk), .we(accept & req_write & (tgt == TGT_ITCM)), .size(req_size),
    .idx(idx[IT_AW-1:0]), .wdata(req_wdata), .rword(w_itcm));
  rmr_bank #(.BYTES(DTCM_BYTES)) u_dtcm (
    .clk(clk), .we(accept & req_write & (tgt == TGT_DTCM)), .size(req_size),
    .idx(idx[DT_AW-1:0]), .wdata(req_wdata), .rword(w_dtcm));
  rmr_bank #(.BYTES(MAIN_BYTES)) u_main (
    .clk(clk), .we(accept & req_write & (tgt == TGT_MAIN)), .size(req_size),
    .idx(idx[MN_AW-1:0]), .wdata(req_wdata), .rword(w_main));
  rmr_bank #(.BYTES(SHR_BYTES)) u_shr (
    .clk(clk), .we(accept & req_write & (tgt == TGT_SHR)), .size(req_size),
    .idx(idx[SH_AW-1:0]), .wdata(req_wdata), .rword(w_shr));
  rmr_bank #(.BYTES(PRV_BYTES)) u_prv (
    .clk(clk), .we(accept & req_write & (tgt == TGT_PRV)), .size(req_size),
    .idx(idx[PV_AW-1:0]), .wdata(req_wdata), .rword(w_prv));

  // IO register port: two 16-bit read lanes, one store strobe.
  assign io_raddr0 = wide ? {idx[23:2], 2'b00} : idx;
  assign io_raddr1 = {idx[23:2], 2'b10};
  assign io_we     = accept & req_write & (tgt == TGT_IO);
  assign io_waddr  = idx;
  assign io_wdata  = req_wdata;
  assign io_wsize  = req_size;

  always_comb begin
    unique case (tgt)
      TGT_ITCM: bank_word = w_itcm;
      TGT_DTCM: bank_word = w_dtcm;
      TGT_MAIN: bank_word = w_main;
      TGT_SHR:  bank_word = w_shr;
      TGT_PRV:  bank_word = w_prv;
      default:  bank_word = 32'd0;
    endcase
  end

  always_comb begin
    if (tgt == TGT_IO) begin
      if (wide)                raw = {io_rdata1, io_rdata0};
      else if (req_size == 2'd1) raw = {16'd0, io_rdata0};
      else                     raw = {24'd0, io_rdata0[7:0]};
    end else begin
      if (wide)                raw = bank_word;
      else if (req_size == 2'd1) raw = {16'd0, idx[1] ? bank_word[31:16] : bank_word[15:0]};
      else                     raw = {24'd0, bank_word[8*idx[1:0] +: 8]};
    end
  end

  assign sh  = wide ? {req_addr[1:0], 3'b000} :
               (req_size == 2'd1) ? {1'b0, req_addr[0], 3'b000} : 5'd0;
  assign rot = (raw >> sh) | (raw << (6'd32 - {1'b0, sh}));

  always_comb begin
    if (req_write)      rdata_n = 32'd0;
    else if (fetch_bad) rdata_n = UNDEF_OPCODE;
    else if (miss)      rdata_n = 32'd0;
    else                rdata_n = rot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
      rsp_cost  <= 5'd0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata_n;
      rsp_cost  <= cost;
      rsp_err   <= miss;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rmr_checker.sv
module rmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_fetch,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [4:0]  rsp_cost,
  input logic        rsp_err,
  input logic        io_we
);
  logic acc;
  assign acc = req_valid & req_ready;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_cost) && $stable(rsp_err));

  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_cost_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cost >= 5'd1) && (rsp_cost <= 5'd21));

  p_far_cost_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && (req_addr[31:24] >= 8'd8) |=> rsp_cost == 5'd2);

  p_io_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_we |-> acc && req_write && (req_addr[31:24] == 8'h04));

  p_bad_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_fetch && !req_write && (req_addr[31:24] >= 8'd5)
      |=> rsp_err && (rsp_rdata == 32'hE710B710) && (rsp_cost == 5'd2));

  p_unmapped_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_fetch && !req_write && (req_addr[31:24] >= 8'd5)
      |=> rsp_err && (rsp_rdata == 32'd0));

  p_unmapped_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && (req_addr[31:24] >= 8'd5) |-> !io_we);
endmodule

bind region_mem_router rmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_fetch(req_fetch), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_cost(rsp_cost), .rsp_err(rsp_err), .io_we(io_we)
);

// File: tb/sim_region_mem_router.sv
module sim_region_mem_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_seq = 1'b0, req_fetch = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0, req_wdata = 32'd0;
  logic        req_ready, rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [4:0]  rsp_cost;
  logic [4:0]  cfg_itcm_vsize = 5'd0;
  logic [31:0] cfg_dtcm_base = 32'h0200_0800;
  logic [8:0]  cfg_shr_bytes = 9'd256;
  logic [23:0] io_raddr0, io_raddr1, io_waddr;
  logic [15:0] io_rdata0, io_rdata1;
  logic        io_we;
  logic [31:0] io_wdata;
  logic [1:0]  io_wsize;

  int n_cmp = 0;
  int n_bad = 0;
  int io_cnt = 0;
  logic [23:0] cap_a = '0;
  logic [31:0] cap_d = '0;
  logic [1:0]  cap_s = '0;

  always #5 clk = ~clk;

  // IO register model: data depends on the address.
  assign io_rdata0 = io_raddr0[15:0] ^ 16'h5A3C;
  assign io_rdata1 = io_raddr1[15:0] ^ 16'h5A3C;

  always @(posedge clk) begin
    if (io_we) begin
      io_cnt <= io_cnt + 1;
      cap_a  <= io_waddr;
      cap_d  <= io_wdata;
      cap_s  <= io_wsize;
    end
  end

  region_mem_router u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_seq(req_seq),
    .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_cost(rsp_cost), .rsp_err(rsp_err), .cfg_itcm_vsize(cfg_itcm_vsize),
    .cfg_dtcm_base(cfg_dtcm_base), .cfg_shr_bytes(cfg_shr_bytes),
    .io_raddr0(io_raddr0), .io_raddr1(io_raddr1), .io_rdata0(io_rdata0),
    .io_rdata1(io_rdata1), .io_we(io_we), .io_waddr(io_waddr),
    .io_wdata(io_wdata), .io_wsize(io_wsize)
  );

  typedef struct packed {
    logic        w;
    logic [1:0]  sz;
    logic        sq;
    logic        f;
    logic [31:0] a;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [4:0]  c;
    logic        e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0200_0010, 32'h1122_3344, 32'h0000_0000, 5'd20, 1'b0, 4'd2},  // R2 store word
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0200_0010, 32'h0, 32'h1122_3344, 5'd21, 1'b0, 4'd2},          // R2 load word
    '{1'b0, 2'd2, 1'b1, 1'b0, 32'h0200_0011, 32'h0, 32'h4411_2233, 5'd5,  1'b0, 4'd7},          // R7 rotate word
    '{1'b0, 2'd1, 1'b0, 1'b0, 32'h0200_0012, 32'h0, 32'h0000_1122, 5'd19, 1'b0, 4'd7},          // R7 half
    '{1'b0, 2'd1, 1'b0, 1'b0, 32'h0200_0013, 32'h0, 32'h2200_0011, 5'd19, 1'b0, 4'd7},          // R7 odd half
    '{1'b0, 2'd0, 1'b1, 1'b0, 32'h0200_0011, 32'h0, 32'h0000_0033, 5'd3,  1'b0, 4'd7},          // R7 byte
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0200_0004, 32'hAAAA_5555, 32'h0, 5'd20, 1'b0, 4'd4},          // R4 main marker
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0200_0804, 32'hCAFE_F00D, 32'h0, 5'd20, 1'b0, 4'd4},          // R4 dtcm store
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0200_0804, 32'h0, 32'hCAFE_F00D, 5'd21, 1'b0, 4'd4},          // R4 dtcm hit
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0200_0004, 32'h0, 32'hAAAA_5555, 5'd21, 1'b0, 4'd4},          // R4 main intact
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0200_0C04, 32'h0, 32'hAAAA_5555, 5'd21, 1'b0, 4'd4},          // R4 alias misses dtcm
    '{1'b0, 2'd2, 1'b0, 1'b1, 32'h0200_0804, 32'h0, 32'hAAAA_5555, 5'd21, 1'b0, 4'd4},          // R4 fetch bypasses dtcm
    '{1'b1, 2'd2, 1'b1, 1'b0, 32'h0000_0100, 32'h0102_0304, 32'h0, 5'd2,  1'b0, 4'd5},          // R5 itcm store seq
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_0200, 32'hFFFF_FFFF, 32'h0, 5'd7,  1'b1, 4'd5},          // R5 out of window
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0102_0304, 5'd8,  1'b0, 4'd5},          // R5 drop confirmed
    '{1'b0, 2'd2, 1'b1, 1'b1, 32'h0000_0000, 32'h0, 32'h0102_0304, 5'd8,  1'b0, 4'd11},         // R11 fetch nonseq
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0300_0020, 32'hDEAD_BEEF, 32'h0, 5'd7,  1'b0, 4'd6},          // R6 shared
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0380_0020, 32'h1234_5678, 32'h0, 5'd7,  1'b0, 4'd6},          // R6 private
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0300_0020, 32'h0, 32'hDEAD_BEEF, 5'd8,  1'b0, 4'd6},          // R6 shared read
    '{1'b0, 2'd2, 1'b1, 1'b0, 32'h0380_0020, 32'h0, 32'h1234_5678, 5'd3,  1'b0, 4'd6},          // R6 private read seq
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0300_0000, 32'h0BAD_F00D, 32'h0, 5'd7,  1'b0, 4'd6},          // R6 shared idx 0
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h04AB_0106, 32'h0, 32'h5B38_5B3A, 5'd8,  1'b0, 4'd8},          // R8 io word
    '{1'b0, 2'd1, 1'b0, 1'b0, 32'h0400_0105, 32'h0, 32'h3900_005B, 5'd8,  1'b0, 4'd8},          // R8 io half odd
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h0800_0000, 32'h0, 32'h0000_0000, 5'd2,  1'b1, 4'd3},          // R3 / R10
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0500_0000, 32'h5555_AAAA, 32'h0, 5'd10, 1'b1, 4'd10},         // R10 store
    '{1'b0, 2'd2, 1'b0, 1'b1, 32'h0600_0000, 32'h0, 32'hE710_B710, 5'd2,  1'b1, 4'd9},          // R9 bad fetch
    '{1'b0, 2'd0, 1'b0, 1'b0, 32'h0700_0003, 32'h0, 32'h0000_0000, 5'd8,  1'b1, 4'd10}          // R10 byte load
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic w, input logic [1:0] sz, input logic sq, input logic f,
                     input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic [4:0] c, output logic e);
    @(negedge clk);
    req_write = w; req_size = sz; req_seq = sq; req_fetch = f;
    req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; c = rsp_cost; e = rsp_err;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [4:0]  c;
    logic        e;

    repeat (3) @(negedge clk);
    chk("R12 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R12 req_ready after reset", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      run(VT[i].w, VT[i].sz, VT[i].sq, VT[i].f, VT[i].a, VT[i].wd, rd, c, e);
      chk($sformatf("R%0d row %0d rdata", VT[i].rq, i), rd, VT[i].rd);
      chk($sformatf("R%0d row %0d cost", VT[i].rq, i), {27'd0, c}, {27'd0, VT[i].c});
      chk($sformatf("R%0d row %0d err", VT[i].rq, i), {31'd0, e}, {31'd0, VT[i].e});
    end
    chk("R10 no io strobe from unmapped store", io_cnt, 0);

    // R1: back-pressure holds the response and stalls requests.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_write = 1'b0; req_size = 2'd2; req_seq = 1'b0; req_fetch = 1'b0;
    req_addr = 32'h0200_0010; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1 held valid", {31'd0, rsp_valid}, 32'd1);
      chk("R1 stalled ready", {31'd0, req_ready}, 32'd0);
      chk("R1 held data", rsp_rdata, 32'h1122_3344);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 drained", {31'd0, rsp_valid}, 32'd0);

    // R5: mirror region opens only with a large window.
    run(1'b0, 2'd2, 1'b0, 1'b0, 32'h0100_0000, 32'h0, rd, c, e);
    chk("R5 mirror closed err", {31'd0, e}, 32'd1);
    chk("R5 mirror closed data", rd, 32'd0);
    cfg_itcm_vsize = 5'd16;
    run(1'b0, 2'd2, 1'b0, 1'b0, 32'h0100_0000, 32'h0, rd, c, e);
    chk("R5 mirror open data", rd, 32'h0102_0304);
    chk("R5 mirror open cost", {27'd0, c}, 32'd8);
    cfg_itcm_vsize = 5'd0;

    // R6: shared size steers the work-RAM window.
    cfg_shr_bytes = 9'd0;
    run(1'b0, 2'd2, 1'b0, 1'b0, 32'h0300_0020, 32'h0, rd, c, e);
    chk("R6 zero shared -> private", rd, 32'h1234_5678);
    cfg_shr_bytes = 9'd16;
    run(1'b0, 2'd2, 1'b0, 1'b0, 32'h0300_0010, 32'h0, rd, c, e);
    chk("R6 small shared wraps", rd, 32'h0BAD_F00D);
    chk("R6 cost", {27'd0, c}, 32'd8);
    cfg_shr_bytes = 9'd256;

    // R8: IO half store.
    run(1'b1, 2'd1, 1'b0, 1'b0, 32'h0412_3456, 32'h0000_BEEF, rd, c, e);
    chk("R8 io strobe count", io_cnt, 1);
    chk("R8 io waddr", {8'd0, cap_a}, 32'h0012_3456);
    chk("R8 io wdata", cap_d, 32'h0000_BEEF);
    chk("R8 io wsize", {30'd0, cap_s}, 32'd1);
    chk("R2 io half store cost", {27'd0, c}, 32'd7);
    chk("R7 store rdata zero", rd, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule